// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Memory with Write Forwarding

This block is a synchronous memory with one read port and one write port. Both ports can accept a command in the same clock cycle. Every command moves a pair of data words. The first word of a pair sits at an even word location and the second word sits at the odd location just above it. A command carries only the pair (burst) index. Write data and per-byte write enables arrive one cycle after the write command. Read data appears two cycles after the read command, together with a one-cycle valid strobe.

A read normally returns the contents left by every write whose data has already arrived. One case needs care: a read and a write to the same pair loaded in the same cycle. The write's data is still on its way when the read looks into the array. The block merges that arriving data into the read result byte by byte, so a read never returns a value older than a write that was accepted with it. Address, data and byte-lane widths are parameters.

Top module: `pair_burst_ram`

## Requirements
- R1: While reset (rstN low) is held and after its release, rdValid is 0 and both read data beats are 0 until the first read completes.
- R2: rdValid is 1 in exactly the second cycle after a cycle with rdEn high, and 0 otherwise.
- R3: A write command in cycle T takes wrData0 and wrData1 in cycle T+1. wrData0 goes to word 2*wrAddr and wrData1 goes to word 2*wrAddr+1. A read of the same pair returns them as rdData0 and rdData1.
- R4: wrByteEn bit k of the data cycle governs byte lane k of beat 0 for k < BYTES, and lane k-BYTES of beat 1 otherwise. Lane j occupies data bits [j*8+7 : j*8] at the default widths. A lane whose bit is 0 keeps its stored value.
- R5: A read command issued in any cycle after a write command returns that write's data.
- R6: A read and a write to the same pair in the same cycle make the read return the write's arriving data in enabled lanes and the stored data in disabled lanes.
- R7: A read command issued one cycle before a write to the same pair returns the older contents.
- R9: Data and byte-enable inputs in a cycle that does not follow a write command leave the memory unchanged.
- R10: rdData0 and rdData1 hold their value in every cycle in which rdValid is 0.
- R11: Commands may be issued on both ports in every cycle with no gaps, and every read obeys R3 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read command |
| rdAddr | input | ADDR_W-1 | Pair index of the read |
| wrEn | input | 1 | Write command |
| wrAddr | input | ADDR_W-1 | Pair index of the write |
| wrByteEn | input | 2*BYTES | Byte-lane enables, sampled with the write data |
| wrData0 | input | DATA_W | Write beat 0 (even word), one cycle after the command |
| wrData1 | input | DATA_W | Write beat 1 (odd word), one cycle after the command |
| rdData0 | output | DATA_W | Read beat 0 (even word) |
| rdData1 | output | DATA_W | Read beat 1 (odd word) |
| rdValid | output | 1 | Read data valid strobe |

## Verification
The bench targets collisions between the ports. It loads a read and a write to the same pair in the same cycle, with full and with partial lane enables. A design without forwarding would return the stale stored word there. A design that forwarded whole words would wipe out the lanes that were disabled. The bench also reads one cycle before and one cycle after a write to the same pair. A forwarding window that is too wide or too narrow would return the new data too early or the old data too late. Finally, it drives data with no write pending, which must be ignored, and runs long stretches of gap-free random traffic over a few pairs so that collisions happen often.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  // strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic wrCommit;  // write data present this cycle, store it
    logic rdFetch;   // read stage active, capture merged result
    logic fwdHit;    // pending write targets the pair being read
  } pbrStrobes_t;
endpackage

// File: rtl/pbr_ctrl.sv
module pbr_ctrl
  import pbr_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int BURST_W = ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEn,
  input  logic [BURST_W-1:0] rdAddr,
  input  logic               wrEn,
  input  logic [BURST_W-1:0] wrAddr,
  output pbrStrobes_t        strb,
  output logic [BURST_W-1:0] wrBase,
  output logic [BURST_W-1:0] rdBase,
  output logic               rdValid
);
  logic wrPend, rdPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPend  <= 1'b0;
      rdPend  <= 1'b0;
      rdValid <= 1'b0;
      wrBase  <= '0;
      rdBase  <= '0;
    end else begin
      wrPend  <= wrEn;
      rdPend  <= rdEn;
      rdValid <= rdPend;
      if (wrEn) wrBase <= wrAddr;
      if (rdEn) rdBase <= rdAddr;
    end
  end

  always_comb begin
    strb.wrCommit = wrPend;
    strb.rdFetch  = rdPend;
    strb.fwdHit   = wrPend && rdPend && (wrBase == rdBase);
  end
endmodule

// File: rtl/pbr_datapath.sv
module pbr_datapath
  import pbr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BYTES  = 2,
  localparam int BURST_W = ADDR_W - 1,
  localparam int BYTE_W  = DATA_W / BYTES,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pbrStrobes_t            strb,
  input  logic [BURST_W-1:0]     wrBase,
  input  logic [BURST_W-1:0]     rdBase,
  input  logic [2*BYTES-1:0]     wrByteEn,
  input  logic [1:0][DATA_W-1:0] wrBeat,
  output logic [1:0][DATA_W-1:0] rdBeat
);
  logic [DATA_W-1:0]      mem [DEPTH];
  logic [1:0][DATA_W-1:0] merged;

  // read side: stored word, lanes overridden by the arriving write
  always_comb begin
    for (int beat = 0; beat < 2; beat++) begin
      merged[beat] = mem[{rdBase, beat[0]}];
      for (int b = 0; b < BYTES; b++) begin
        if (strb.fwdHit && wrByteEn[beat*BYTES+b])
          merged[beat][b*BYTE_W +: BYTE_W] = wrBeat[beat][b*BYTE_W +: BYTE_W];
      end
    end
  end

  // write side: lane-masked store of both beats
  always_ff @(posedge clk) begin
    if (strb.wrCommit) begin
      for (int beat = 0; beat < 2; beat++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (wrByteEn[beat*BYTES+b])
            mem[{wrBase, beat[0]}][b*BYTE_W +: BYTE_W] <= wrBeat[beat][b*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdBeat <= '0;
    else if (strb.rdFetch)  rdBeat <= merged;
  end
endmodule

// File: rtl/pair_burst_ram.sv
module pair_burst_ram
  import pbr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BYTES  = 2,
  localparam int BURST_W = ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEn,
  input  logic [BURST_W-1:0] rdAddr,
  input  logic               wrEn,
  input  logic [BURST_W-1:0] wrAddr,
  input  logic [2*BYTES-1:0] wrByteEn,
  input  logic [DATA_W-1:0]  wrData0,
  input  logic [DATA_W-1:0]  wrData1,
  output logic [DATA_W-1:0]  rdData0,
  output logic [DATA_W-1:0]  rdData1,
  output logic               rdValid
);
  pbrStrobes_t            strb;
  logic [BURST_W-1:0]     wrBase, rdBase;
  logic [1:0][DATA_W-1:0] wrBeat, rdBeat;

  assign wrBeat  = {wrData1, wrData0};
  assign rdData0 = rdBeat[0];
  assign rdData1 = rdBeat[1];

  pbr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .strb(strb),
    .wrBase(wrBase), .rdBase(rdBase), .rdValid(rdValid)
  );

  pbr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBase(wrBase), .rdBase(rdBase),
    .wrByteEn(wrByteEn), .wrBeat(wrBeat), .rdBeat(rdBeat)
  );
endmodule

// File: rtl/pair_burst_ram_chk.sv
module pair_burst_ram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BYTES  = 2,
  localparam int BURST_W = ADDR_W - 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               rdEn,
  input logic [BURST_W-1:0] rdAddr,
  input logic               wrEn,
  input logic [BURST_W-1:0] wrAddr,
  input logic [2*BYTES-1:0] wrByteEn,
  input logic [DATA_W-1:0]  wrData0,
  input logic [DATA_W-1:0]  wrData1,
  input logic [DATA_W-1:0]  rdData0,
  input logic [DATA_W-1:0]  rdData1,
  input logic               rdValid
);
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> ##2 rdValid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> ##2 !rdValid);

  assert_fwd_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn && rdAddr == wrAddr) ##1 (&wrByteEn)
      |=> (rdData0 == $past(wrData0) && rdData1 == $past(wrData1)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> ($stable(rdData0) && $stable(rdData1)));
endmodule

bind pair_burst_ram pair_burst_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_chk (.*);

// File: tb/pair_burst_ram_bench.sv
`timescale 1ns/1ps
module pair_burst_ram_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = 2;
  localparam int BA = AW - 1;
  localparam int LW = DW / NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdEn = 1'b0, wrEn = 1'b0;
  logic [BA-1:0] rdAddr = '0, wrAddr = '0;
  logic [2*NB-1:0] wrByteEn = '0;
  logic [DW-1:0] wrData0 = '0, wrData1 = '0;
  logic [DW-1:0] rdData0, rdData1;
  logic          rdValid;

  always #2 clk = ~clk;

  pair_burst_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTES(NB)) u_pair_burst_ram (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrByteEn(wrByteEn), .wrData0(wrData0), .wrData1(wrData1),
    .rdData0(rdData0), .rdData1(rdData1), .rdValid(rdValid)
  );

  int    nChecks = 0, nFail = 0, cycles = 0;
  bit    started = 0;
  string phase = "R1";

  // behavioural reference: word array plus one-deep command memory per port
  logic [DW-1:0] mm [1 << AW];
  bit            mWr, mRd;
  int            mWrBase, mRdBase;
  logic          expValid;
  logic [DW-1:0] expD [2];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWr = 0; mRd = 0; expValid = 0; expD[0] = '0; expD[1] = '0;
    end else begin
      logic [DW-1:0] inBeat [2];
      inBeat[0] = wrData0; inBeat[1] = wrData1;
      expValid = mRd;
      if (mRd) begin
        for (int k = 0; k < 2; k++) begin
          logic [DW-1:0] w;
          w = mm[mRdBase*2 + k];
          if (mWr && mWrBase == mRdBase)
            for (int j = 0; j < NB; j++)
              if (wrByteEn[k*NB+j]) w[j*LW +: LW] = inBeat[k][j*LW +: LW];
          expD[k] = w;
        end
      end
      if (mWr)
        for (int k = 0; k < 2; k++)
          for (int j = 0; j < NB; j++)
            if (wrByteEn[k*NB+j]) mm[mWrBase*2 + k][j*LW +: LW] = inBeat[k][j*LW +: LW];
      mWr = wrEn; mWrBase = int'(wrAddr);
      mRd = rdEn; mRdBase = int'(rdAddr);
    end
  end

  always @(negedge clk) begin
    if (rstN && started) begin
      nChecks++;
      if (rdValid !== expValid) begin
        nFail++;
        $display("FAIL %s (R2 strobe): rdValid got %0b expected %0b", phase, rdValid, expValid);
      end
      nChecks++;
      if (rdData0 !== expD[0] || rdData1 !== expD[1]) begin
        nFail++;
        $display("FAIL %s%s: rdData got %h_%h expected %h_%h", phase,
                 expValid ? "" : " (R10 hold)", rdData1, rdData0, expD[1], expD[0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: cycles got %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  task automatic cyc(input logic re, input int ra, input logic we, input int wa,
                     input logic [2*NB-1:0] be, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    rdEn = re; rdAddr = BA'(ra); wrEn = we; wrAddr = BA'(wa);
    wrByteEn = be; wrData0 = d0; wrData1 = d1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, '0, '0);
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int beat);
    return DW'(i * 157 + beat * 4099 + 16'h0A05);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    nChecks++;
    if (rdValid !== 1'b0 || rdData0 !== '0 || rdData1 !== '0) begin
      nFail++;
      $display("FAIL R1: got valid %0b data %h_%h expected 0 0000_0000", rdValid, rdData1, rdData0);
    end
    rstN = 1'b1;
    started = 1;
    idle(2);

    phase = "R3 fill";
    for (int i = 0; i <= (1 << BA); i++)
      cyc(0, 0, i < (1 << BA), i, '1, pat(i-1, 0), pat(i-1, 1));
    phase = "R3 readback";
    for (int i = 0; i < (1 << BA); i++) cyc(1, i, 0, 0, '0, '0, '0);
    idle(3);

    phase = "R4 partial lanes";
    cyc(0, 0, 1, 5, '0, '0, '0);
    cyc(0, 0, 0, 0, 4'b0110, 16'h1234, 16'h5678);
    cyc(1, 5, 0, 0, '0, '0, '0);
    idle(3);

    phase = "R5 read after write";
    cyc(0, 0, 1, 6, '0, '0, '0);
    cyc(1, 6, 0, 0, '1, 16'hAAAA, 16'hBBBB);
    idle(3);

    phase = "R6 same-cycle forward";
    cyc(1, 9, 1, 9, '0, '0, '0);
    cyc(0, 0, 0, 0, '1, 16'hBEEF, 16'hCAFE);
    idle(2);
    cyc(1, 10, 1, 10, '0, '0, '0);
    cyc(0, 0, 0, 0, 4'b1001, 16'h1111, 16'h2222);
    idle(3);

    phase = "R7 read before write";
    cyc(1, 11, 0, 0, '0, '0, '0);
    cyc(0, 0, 1, 11, '0, '0, '0);
    cyc(0, 0, 0, 0, '1, 16'h3333, 16'h4444);
    idle(2);
    cyc(1, 11, 0, 0, '0, '0, '0);
    idle(3);

    phase = "R9 stray data";
    cyc(0, 0, 0, 0, '1, 16'hDEAD, 16'hDEAD);
    cyc(0, 0, 0, 0, '1, 16'hDEAD, 16'hDEAD);
    cyc(1, 12, 0, 0, '1, 16'hDEAD, 16'hDEAD);
    idle(3);

    phase = "R11 random traffic";
    for (int i = 0; i < 3000; i++)
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
          (2*NB)'($urandom), DW'($urandom), DW'($urandom));
    idle(4);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule